// File: doc/BRIEF.md
# LDPC Bit Node Message Processor

This block performs the bit-side half of one decoding iteration for a single bit of a low-density parity-check code. A start pulse loads the bit's channel prior, a saturated signed fixed-point log-likelihood ratio. The block then takes one check-to-bit message per cycle over a valid/ready handshake, one for each check the bit belongs to. It adds each message into a running sum and keeps a local copy of it.

Once every connected check has reported, the block registers a hard decision from the sign of the posterior. It then streams out one bit-to-check message per cycle. Each outgoing message is the posterior minus the message that came in from the check it is sent to. The messages leave in the order their inputs arrived, so the surrounding memories can reuse the same address sequence. Internal sums are kept wide enough that they never wrap. Only the outgoing values are clipped to the message format.

Message width is set by the integer and fraction bit counts. The number of checks per bit is also a parameter. The defaults are a 4.2 format and six checks per bit.

Top module: `ldpc_bit_node`

## Requirements
- R1: While reset is asserted and after it is released, in_ready, out_valid, done and hard_bit are all 0.
- R2: A start pulse that arrives while the block is idle or finished captures prior_llr, clears done and raises in_ready in the next cycle. prior_llr is ignored at all other times.
- R3: In_ready stays high until exactly COL_WEIGHT messages have been accepted, one for each cycle with in_valid and in_ready both high. It falls in the cycle after the last message is accepted.
- R4: In the cycle after the last message is accepted, out_valid rises and stays high for exactly COL_WEIGHT consecutive cycles. The k-th output is clip(prior + sum of all inputs - input k), where k counts inputs in arrival order.
- R5: Messages are two's complement with MSG_FRAC fraction bits, so codes step by 2^-MSG_FRAC. The default 6-bit codes span -32..31, that is -8.0 to 7.75. Any result above 31 is output as 31 and any result below -32 is output as -32.
- R6: Intermediate sums never wrap. A result is clipped only at the output, so large partial sums that cancel still give the exact value.
- R7: hard_bit is set in the cycle after the last input is accepted and holds until the next frame's last input. It is 0 when prior plus all inputs is at least zero, and 1 when that total is negative. A total of exactly zero gives 0.
- R8: done rises in the cycle after the last output and stays high until an accepted start.
- R9: A start pulse that arrives while messages are being collected or emitted has no effect on the outputs of the frame in progress.
- R10: in_valid asserted while in_ready is low is ignored, and its in_msg value does not enter any sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a frame when the block is idle or finished |
| prior_llr | input | MSG_INT+MSG_FRAC | Channel prior, captured on an accepted start |
| in_valid | input | 1 | A check-to-bit message is present |
| in_msg | input | MSG_INT+MSG_FRAC | Check-to-bit message |
| in_ready | output | 1 | The block is collecting messages |
| out_valid | output | 1 | out_msg holds a bit-to-check message |
| out_msg | output | MSG_INT+MSG_FRAC | Clipped extrinsic message |
| hard_bit | output | 1 | Hard decision from the posterior sign |
| done | output | 1 | Frame finished |

## Verification
The assertions rely on the block's own handshake and take little for granted about its inputs. They assume that reset starts every run, and that start is the only input that can move the block out of the idle and finished states. Collecting, emitting and finished are taken to be mutually exclusive, which follows from the block's own control. The bench keeps to these assumptions. It also pulses start and drives in_valid at moments when the block must ignore them, so the properties are checked on those paths as well. Inputs always stay within the signed message codes, and the messages chosen include cases that push partial sums far beyond the clip limits.

// File: rtl/ldpc_bit_node_pkg.sv
package ldpc_bit_node_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_COLLECT = 2'd1,
    PH_EMIT    = 2'd2,
    PH_DONE    = 2'd3
  } phase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadPrior;
    logic acceptMsg;
    logic lastAccept;
  } nodeCtrl_t;

endpackage

// File: rtl/ldpc_bit_node_ctrl.sv
module ldpc_bit_node_ctrl
  import ldpc_bit_node_pkg::*;
#(
  parameter int COL_WEIGHT = 6,
  localparam int IDXW = (COL_WEIGHT > 1) ? $clog2(COL_WEIGHT) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            inValid,
  output logic            inReady,
  output logic            outValid,
  output logic            doneFlag,
  output logic [IDXW-1:0] edgeIdx,
  output nodeCtrl_t       ctrl
);

  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(COL_WEIGHT - 1);

  phase_t          phase, phaseNext;
  logic [IDXW-1:0] idxNext;

  always_comb begin
    phaseNext       = phase;
    idxNext         = edgeIdx;
    ctrl.loadPrior  = 1'b0;
    ctrl.acceptMsg  = 1'b0;
    ctrl.lastAccept = 1'b0;
    unique case (phase)
      PH_IDLE, PH_DONE: begin
        if (start) begin
          ctrl.loadPrior = 1'b1;
          phaseNext      = PH_COLLECT;
          idxNext        = '0;
        end
      end
      PH_COLLECT: begin
        if (inValid) begin
          ctrl.acceptMsg = 1'b1;
          if (edgeIdx == LAST_IDX) begin
            ctrl.lastAccept = 1'b1;
            phaseNext       = PH_EMIT;
            idxNext         = '0;
          end else begin
            idxNext = edgeIdx + 1'b1;
          end
        end
      end
      PH_EMIT: begin
        if (edgeIdx == LAST_IDX) begin
          phaseNext = PH_DONE;
          idxNext   = '0;
        end else begin
          idxNext = edgeIdx + 1'b1;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      edgeIdx <= '0;
    end else begin
      phase   <= phaseNext;
      edgeIdx <= idxNext;
    end
  end

  assign inReady  = (phase == PH_COLLECT);
  assign outValid = (phase == PH_EMIT);
  assign doneFlag = (phase == PH_DONE);

endmodule

// File: rtl/ldpc_bit_node_dp.sv
module ldpc_bit_node_dp
  import ldpc_bit_node_pkg::*;
#(
  parameter int MSG_INT    = 4,
  parameter int MSG_FRAC   = 2,
  parameter int COL_WEIGHT = 6,
  localparam int W    = MSG_INT + MSG_FRAC,
  localparam int IDXW = (COL_WEIGHT > 1) ? $clog2(COL_WEIGHT) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  nodeCtrl_t       ctrl,
  input  logic [IDXW-1:0] edgeIdx,
  input  logic [W-1:0]    priorIn,
  input  logic [W-1:0]    msgIn,
  output logic [W-1:0]    msgOut,
  output logic            hardBit
);

  // Guard bits: sum of COL_WEIGHT+1 terms, plus a subtraction
  localparam int ACCW = W + $clog2(COL_WEIGHT + 1) + 1;
  localparam logic signed [ACCW-1:0] SAT_HI = ACCW'((2 ** (W - 1)) - 1);
  localparam logic signed [ACCW-1:0] SAT_LO = -SAT_HI - 1;

  logic signed [ACCW-1:0] accSum;
  logic signed [ACCW-1:0] priorWide, msgWide, bufWide, accNext, extrinsic;
  logic [W-1:0]           msgBuf [COL_WEIGHT];

  assign priorWide = {{(ACCW - W){priorIn[W-1]}}, priorIn};
  assign msgWide   = {{(ACCW - W){msgIn[W-1]}}, msgIn};
  assign accNext   = accSum + msgWide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accSum  <= '0;
      hardBit <= 1'b0;
    end else begin
      if (ctrl.loadPrior) accSum <= priorWide;
      else if (ctrl.acceptMsg) accSum <= accNext;
      if (ctrl.lastAccept) hardBit <= accNext[ACCW-1];
    end
  end

  // One storage slot per connected check
  for (genvar g = 0; g < COL_WEIGHT; g++) begin : gSlot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) msgBuf[g] <= '0;
      else if (ctrl.acceptMsg && (edgeIdx == IDXW'(g))) msgBuf[g] <= msgIn;
    end
  end

  assign bufWide   = {{(ACCW - W){msgBuf[edgeIdx][W-1]}}, msgBuf[edgeIdx]};
  assign extrinsic = accSum - bufWide;

  always_comb begin
    if (extrinsic > SAT_HI)      msgOut = SAT_HI[W-1:0];
    else if (extrinsic < SAT_LO) msgOut = SAT_LO[W-1:0];
    else                         msgOut = extrinsic[W-1:0];
  end

endmodule

// File: rtl/ldpc_bit_node.sv
module ldpc_bit_node
  import ldpc_bit_node_pkg::*;
#(
  parameter int MSG_INT    = 4,
  parameter int MSG_FRAC   = 2,
  parameter int COL_WEIGHT = 6,
  localparam int W    = MSG_INT + MSG_FRAC,
  localparam int IDXW = (COL_WEIGHT > 1) ? $clog2(COL_WEIGHT) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] prior_llr,
  input  logic         in_valid,
  input  logic [W-1:0] in_msg,
  output logic         in_ready,
  output logic         out_valid,
  output logic [W-1:0] out_msg,
  output logic         hard_bit,
  output logic         done
);

  nodeCtrl_t       ctrl;
  logic [IDXW-1:0] edgeIdx;

  ldpc_bit_node_ctrl #(.COL_WEIGHT(COL_WEIGHT)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .inValid(in_valid),
    .inReady(in_ready), .outValid(out_valid), .doneFlag(done),
    .edgeIdx(edgeIdx), .ctrl(ctrl)
  );

  ldpc_bit_node_dp #(.MSG_INT(MSG_INT), .MSG_FRAC(MSG_FRAC), .COL_WEIGHT(COL_WEIGHT)) dp_i (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .edgeIdx(edgeIdx),
    .priorIn(prior_llr), .msgIn(in_msg), .msgOut(out_msg), .hardBit(hard_bit)
  );

endmodule

// File: rtl/ldpc_bit_node_chk.sv
module ldpc_bit_node_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic in_ready,
  input logic out_valid,
  input logic hard_bit,
  input logic done
);

  // R3 R4 R8: collecting, emitting and finished never overlap
  a_r3_phases_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_ready, out_valid, done}));

  // R2: an accepted start opens the input in the next cycle
  a_r2_start_opens_input: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !in_ready && !out_valid) |=> in_ready);

  // R8: done holds until a start arrives
  a_r8_done_held: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R8: the end of the output burst is followed by done
  a_r8_done_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> done);

  // R7: the decision does not move while messages are emitted
  a_r7_decision_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> $stable(hard_bit));

  // R4: output burst follows input collection directly
  a_r4_emit_after_collect: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_ready));

endmodule

bind ldpc_bit_node ldpc_bit_node_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .in_ready(in_ready),
  .out_valid(out_valid), .hard_bit(hard_bit), .done(done)
);

// File: tb/ldpc_bit_node_tb_top.sv
module ldpc_bit_node_tb_top;

  localparam int CW = 6;
  localparam int W  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] prior_llr = '0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_msg = '0;
  logic in_ready, out_valid, hard_bit, done;
  logic signed [W-1:0] out_msg;

  int checks = 0;
  int fails = 0;
  int expQ[$];
  bit expHard = 1'b0;
  string curTag = "R4";

  always #4 clk = ~clk;

  ldpc_bit_node dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .prior_llr(prior_llr),
    .in_valid(in_valid), .in_msg(in_msg), .in_ready(in_ready),
    .out_valid(out_valid), .out_msg(out_msg), .hard_bit(hard_bit), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int clip(input int v);
    if (v > 31) return 31;
    if (v < -32) return -32;
    return v;
  endfunction

  // Scoreboard monitor: compare each emitted message and the decision
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R4 unexpected output", int'(out_msg), 0);
      end else begin
        int e;
        e = expQ.pop_front();
        check(int'(out_msg) == e, {curTag, " R5 R6 extrinsic"}, int'(out_msg), e);
      end
      check(hard_bit == expHard, "R7 hard decision", int'(hard_bit), int'(expHard));
    end
  end

  task automatic runFrame(input int prior, input int m[CW], input bit gaps,
                          input bit startInCollect, input bit startInEmit, input string tag);
    int total;
    total = prior;
    for (int k = 0; k < CW; k++) total += m[k];
    for (int k = 0; k < CW; k++) expQ.push_back(clip(total - m[k]));
    curTag = tag;
    @(negedge clk);
    start = 1'b1;
    prior_llr = W'(prior);
    @(negedge clk);
    start = 1'b0;
    prior_llr = W'(-prior - 1);  // R2: ignored after capture
    expHard = (total < 0);
    check(in_ready == 1'b1 && done == 1'b0, "R2 input opens", int'(in_ready), 1);
    for (int k = 0; k < CW; k++) begin
      if (gaps && (k % 2 == 1)) begin
        in_valid = 1'b0;
        in_msg = 6'h1F;
        @(negedge clk);
        check(in_ready == 1'b1, "R3 ready through gap", int'(in_ready), 1);
      end
      in_valid = 1'b1;
      in_msg = W'(m[k]);
      start = (startInCollect && k == 3);
      @(negedge clk);
      start = 1'b0;
      if (k < CW - 1) check(in_ready == 1'b1, "R3 ready until last", int'(in_ready), 1);
    end
    in_valid = 1'b0;
    for (int i = 0; i < CW; i++) begin
      check(out_valid == 1'b1 && in_ready == 1'b0, "R3 R4 output burst", int'(out_valid), 1);
      start = (startInEmit && i == 2);  // R9
      @(negedge clk);
    end
    start = 1'b0;
    check(done == 1'b1 && out_valid == 1'b0, "R8 done after burst", int'(done), 1);
    repeat (2) @(negedge clk);
    check(done == 1'b1, "R8 done held", int'(done), 1);
    check(expQ.size() == 0, {tag, " R4 all outputs seen"}, expQ.size(), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({in_ready, out_valid, done, hard_bit} == 4'b0, "R1 in reset", 1, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({in_ready, out_valid, done, hard_bit} == 4'b0, "R1 after reset", 1, 0);

    // R4: mixed values, no clipping
    runFrame(3, '{2, -5, 7, 0, -1, 4}, 1'b0, 1'b0, 1'b0, "R4");
    // R5: upper clip
    runFrame(31, '{31, 31, 31, 31, 31, 31}, 1'b0, 1'b0, 1'b0, "R5");
    // R5: lower clip, negative decision
    runFrame(-32, '{-32, -32, -32, -32, -32, -32}, 1'b0, 1'b0, 1'b0, "R5");
    // R7: posterior exactly zero gives 0
    runFrame(0, '{5, -5, 3, -3, 0, 0}, 1'b0, 1'b0, 1'b0, "R7");
    // R6: large partial sums that cancel
    runFrame(31, '{31, 31, -32, -32, -32, 2}, 1'b0, 1'b0, 1'b0, "R6");
    // R5: just below the lower limit
    runFrame(-20, '{-13, 0, 0, 0, 0, 0}, 1'b0, 1'b0, 1'b0, "R5");

    // R10: valid input while not ready must not be absorbed
    in_valid = 1'b1;
    in_msg = 6'h1F;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b0 && done == 1'b1, "R10 not ready when finished", int'(in_ready), 0);
    in_valid = 1'b0;
    // R9 R3: gaps plus start pulses mid-frame
    runFrame(-7, '{1, -2, 3, -4, 5, -6}, 1'b1, 1'b1, 1'b1, "R9");

    for (int f = 0; f < 6; f++) begin
      int pr;
      int mm[CW];
      pr = int'($urandom_range(0, 63)) - 32;
      for (int k = 0; k < CW; k++) mm[k] = int'($urandom_range(0, 63)) - 32;
      runFrame(pr, mm, f[0], 1'b0, 1'b0, "R4");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule